// File: doc/BRIEF.md
# Dual-Tone Period-Counting Classifier

This block turns two squared tone signals into a key code. One input carries the squared output of the low-band path and the other carries the squared output of the high-band path. Both come from zero-crossing comparators. Rising edges on each input are timed against a fast reference clock, nominally 3.579545 MHz. A group of consecutive periods is summed, and the sum is compared with a window around each of the four nominal frequencies of that band.

A band is declared valid when the same frequency wins in consecutive measurements. Any of the following clears it: a measurement that fits no window, a change of frequency, or a silence longer than the timeout. When both bands are valid, the block raises a present flag and drives a 4-bit key code. An inhibit input stops the fourth high-band column (1633 Hz, keys A to D) from ever being reported.

The block sits after the analog band-split filters and comparators. It sits before any duration-guard or latching logic, which is not part of this block.

Top module: `tone_pair_classifier`

## Requirements
- R1: While `rst_n` is low, at every clock edge `tone_present` is forced to 0 and `tone_code` to 4'b0000, including when tones are active on both inputs.
- R2: A low-band input whose frequency (reference clock divided by its period in cycles) lies within ±1.5 % of 697, 770, 852 or 941 Hz is classified as row 0, 1, 2 or 3 respectively.
- R3: A high-band input whose frequency lies within ±1.5 % of 1209, 1336, 1477 or 1633 Hz is classified as column 0, 1, 2 or 3 respectively.
- R4: An input that deviates by more than ±1.5 % from every nominal of its band, including the 1.5 % to 3.5 % zone and deviations of 3.5 % or more, leaves its band invalid, so `tone_present` stays 0.
- R5: A band becomes valid only after two consecutive measurements, each a sum of 4 periods, classify to the same nominal. A pair is therefore not reported within the first 6 low-band periods after the tones start.
- R6: The key code on `tone_code[3:0]` uses the standard 4x4 keypad layout. Rows 0 to 3 are 697 to 941 Hz and columns 0 to 3 are 1209 to 1633 Hz, giving the keypad rows "1 2 3 A", "4 5 6 B", "7 8 9 C" and "* 0 # D". Digits 1 to 9 encode as 1 to 9, '0' as 10, '*' as 11, '#' as 12, 'A' as 13, 'B' as 14, 'C' as 15 and 'D' as 0.
- R7: While `inhibit_col4` is high, a pair in column 3 (1633 Hz) is never reported. Pairs in columns 0 to 2 are unaffected.
- R8: `tone_present` is 1 only when both bands are valid at the same time. A tone on one input alone gives `tone_present` = 0.
- R9: If an input shows no rising edge for TIMEOUT reference cycles, its band is cleared, and `tone_present` falls a few cycles later.
- R10: Whenever `tone_present` is 0, `tone_code` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_sq | input | 1 | Squared low-band signal (asynchronous, synchronised inside) |
| high_sq | input | 1 | Squared high-band signal (asynchronous, synchronised inside) |
| inhibit_col4 | input | 1 | High: suppress pairs in the 1633 Hz column |
| tone_present | output | 1 | Registered flag: a valid tone pair is being classified |
| tone_code | output | 4 | Registered key code of the current pair; zero when none |

## Verification
The bench places inputs just inside the acceptance window, in the grey zone between 1.5 % and 3.5 %, and beyond 3.5 %. A design with windows that are too wide, or that swapped its ceiling and floor rounding, would then report pairs it should reject. It walks all sixteen key pairs, because a transposed row/column index or a wrong entry for '0', '*', '#' or 'D' is otherwise invisible. It checks that nothing is reported six low periods after the start; a design that trusted a single measurement would already be reporting. It removes one tone while the other stays, and raises the column inhibit on both a column-3 key and a column-1 key. These catch a band that never times out, and an inhibit that masks the wrong column or every column.

// File: rtl/tpc_pkg.sv
// Package tpc_pkg
// Shared constants and helpers for the tone-pair classifier: the nominal
// frequency table, the acceptance window bounds (in summed reference-clock
// cycles) and the keypad code map. All functions are usable at elaboration.
package tpc_pkg;

    // Nominal tone frequency of one band member, in Hz.
    function automatic longint unsigned nominal_hz(input bit high_band, input int unsigned idx);
        longint unsigned f;
        if (high_band) begin
            case (idx)
                0:       f = 64'd1209;
                1:       f = 64'd1336;
                2:       f = 64'd1477;
                default: f = 64'd1633;
            endcase
        end else begin
            case (idx)
                0:       f = 64'd697;
                1:       f = 64'd770;
                2:       f = 64'd852;
                default: f = 64'd941;
            endcase
        end
        return f;
    endfunction

    // Smallest accepted sum of navg periods (tone at +tol_bp basis points).
    function automatic longint unsigned window_lo(input longint unsigned ref_hz,
                                                  input longint unsigned f_hz,
                                                  input longint unsigned navg,
                                                  input longint unsigned tol_bp);
        longint unsigned num;
        longint unsigned den;
        num = navg * ref_hz * 64'd10000;
        den = f_hz * (64'd10000 + tol_bp);
        return (num + den - 64'd1) / den;
    endfunction

    // Largest accepted sum of navg periods (tone at -tol_bp basis points).
    function automatic longint unsigned window_hi(input longint unsigned ref_hz,
                                                  input longint unsigned f_hz,
                                                  input longint unsigned navg,
                                                  input longint unsigned tol_bp);
        longint unsigned num;
        longint unsigned den;
        num = navg * ref_hz * 64'd10000;
        den = f_hz * (64'd10000 - tol_bp);
        return num / den;
    endfunction

    // Keypad code of a (row, column) pair.
    function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] c;
        if (col == 2'd3) begin
            c = 4'({2'b00, row} + 4'd13);
        end else if (row != 2'd3) begin
            c = 4'({2'b00, row} * 4'd3 + {2'b00, col} + 4'd1);
        end else begin
            case (col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/tpc_edge_sync.sv
// Module tpc_edge_sync
// Brings an asynchronous squared tone into the clock domain with a
// STAGES-deep flop chain and emits a one-cycle pulse on each rising edge.
// Assumes the input stays high and low for several clock cycles each.
module tpc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_in,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the input through the synchroniser and keep the prior value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], sq_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/tpc_period_meter.sv
// Module tpc_period_meter
// Sums NAVG consecutive periods between rising-edge pulses and emits the
// sum with a one-cycle strobe. The first edge after reset or a timeout only
// opens a window. TIMEOUT cycles without an edge close the window and raise
// tmo_stb. Assumes SUM_W can hold NAVG*TIMEOUT.
module tpc_period_meter #(
    parameter int NAVG    = 4,
    parameter int TIMEOUT = 8192,
    parameter int SUM_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic             meas_stb,
    output logic [SUM_W-1:0] meas_sum,
    output logic             tmo_stb
);

    localparam int IDLE_W = $clog2(TIMEOUT + 1);
    localparam int EDGE_W = $clog2(NAVG + 1);

    logic              armed;
    logic [EDGE_W-1:0] edge_cnt;
    logic [SUM_W-1:0]  sum;
    logic [IDLE_W-1:0] idle;

    // Window accounting: accumulate cycles, count edges, detect silence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            edge_cnt <= '0;
            sum      <= '0;
            idle     <= '0;
            meas_stb <= 1'b0;
            meas_sum <= '0;
            tmo_stb  <= 1'b0;
        end else begin
            meas_stb <= 1'b0;
            tmo_stb  <= 1'b0;
            if (rise) begin
                idle <= '0;
                if (!armed) begin
                    armed    <= 1'b1;
                    sum      <= SUM_W'(1);
                    edge_cnt <= '0;
                end else if (edge_cnt == EDGE_W'(NAVG - 1)) begin
                    meas_stb <= 1'b1;
                    meas_sum <= sum;
                    sum      <= SUM_W'(1);
                    edge_cnt <= '0;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                    sum      <= sum + 1'b1;
                end
            end else if (armed) begin
                if (idle == IDLE_W'(TIMEOUT - 1)) begin
                    armed    <= 1'b0;
                    tmo_stb  <= 1'b1;
                    idle     <= '0;
                    sum      <= '0;
                    edge_cnt <= '0;
                end else begin
                    idle <= idle + 1'b1;
                    sum  <= sum + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tpc_group_classifier.sv
// Module tpc_group_classifier
// Compares each summed measurement of one band with the four acceptance
// windows of that band. The band becomes valid once CONFIRM consecutive
// measurements pick the same nominal. A miss or a timeout clears it.
// Assumes the windows of one band do not overlap (true for ±1.5 %).
module tpc_group_classifier #(
    parameter bit HIGH_BAND = 1'b0,
    parameter int REF_HZ    = 3579545,
    parameter int NAVG      = 4,
    parameter int TOL_BP    = 150,
    parameter int CONFIRM   = 2,
    parameter int SUM_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_stb,
    input  logic [SUM_W-1:0] meas_sum,
    input  logic             tmo_stb,
    output logic             grp_valid,
    output logic [1:0]       grp_idx
);

    localparam int RUN_W = $clog2(CONFIRM + 1);

    logic [63:0]      sum_ext;
    logic [3:0]       hit;
    logic [1:0]       idx_now;
    logic [1:0]       cand;
    logic [RUN_W-1:0] run;

    assign sum_ext = 64'(meas_sum);

    // One window comparator per nominal frequency of this band.
    for (genvar i = 0; i < 4; i++) begin : g_win
        localparam longint unsigned FNOM = tpc_pkg::nominal_hz(HIGH_BAND, i);
        localparam longint unsigned LO   = tpc_pkg::window_lo(64'(REF_HZ), FNOM, 64'(NAVG), 64'(TOL_BP));
        localparam longint unsigned HI   = tpc_pkg::window_hi(64'(REF_HZ), FNOM, 64'(NAVG), 64'(TOL_BP));
        assign hit[i] = (sum_ext >= LO) && (sum_ext <= HI);
    end

    // Encode the (at most one) matching window.
    always_comb begin
        idx_now = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (hit[i]) idx_now = 2'(i);
        end
    end

    // Track how many consecutive measurements agreed on one nominal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= '0;
            cand <= 2'd0;
        end else if (tmo_stb) begin
            run <= '0;
        end else if (meas_stb) begin
            if (hit == 4'd0) begin
                run <= '0;
            end else if (run != '0 && idx_now == cand) begin
                if (run != RUN_W'(CONFIRM)) run <= run + 1'b1;
            end else begin
                cand <= idx_now;
                run  <= RUN_W'(1);
            end
        end
    end

    assign grp_valid = (run == RUN_W'(CONFIRM));
    assign grp_idx   = cand;

endmodule

// File: rtl/tone_pair_classifier.sv
// Module tone_pair_classifier
// Top level: one synchroniser, period meter and classifier per band. A
// registered output stage reports a pair when both bands are valid and the
// column inhibit does not mask it. Assumes clk is the counting reference
// of REF_HZ and TIMEOUT exceeds the slowest accepted period.
module tone_pair_classifier #(
    parameter int REF_HZ  = 3579545,
    parameter int NAVG    = 4,
    parameter int TIMEOUT = 8192,
    parameter int TOL_BP  = 150,
    parameter int CONFIRM = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_sq,
    input  logic       high_sq,
    input  logic       inhibit_col4,
    output logic       tone_present,
    output logic [3:0] tone_code
);

    localparam int SUM_W = $clog2(NAVG * TIMEOUT + 1);

    logic [1:0]       sq_in;
    logic [1:0]       rise;
    logic [1:0]       meas_stb;
    logic [1:0]       tmo_stb;
    logic [1:0]       grp_valid;
    logic [SUM_W-1:0] meas_sum [2];
    logic [1:0]       grp_idx  [2];
    logic             present_nxt;
    logic [3:0]       code_nxt;

    assign sq_in = {high_sq, low_sq};

    // Band 0 is the low band, band 1 the high band.
    for (genvar g = 0; g < 2; g++) begin : g_band
        tpc_edge_sync #(.STAGES(2)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sq_in (sq_in[g]),
            .rise  (rise[g])
        );

        tpc_period_meter #(
            .NAVG    (NAVG),
            .TIMEOUT (TIMEOUT),
            .SUM_W   (SUM_W)
        ) meter_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise[g]),
            .meas_stb (meas_stb[g]),
            .meas_sum (meas_sum[g]),
            .tmo_stb  (tmo_stb[g])
        );

        tpc_group_classifier #(
            .HIGH_BAND (g == 1),
            .REF_HZ    (REF_HZ),
            .NAVG      (NAVG),
            .TOL_BP    (TOL_BP),
            .CONFIRM   (CONFIRM),
            .SUM_W     (SUM_W)
        ) class_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .meas_stb  (meas_stb[g]),
            .meas_sum  (meas_sum[g]),
            .tmo_stb   (tmo_stb[g]),
            .grp_valid (grp_valid[g]),
            .grp_idx   (grp_idx[g])
        );
    end

    // Combine the bands and apply the column inhibit.
    always_comb begin
        present_nxt = (&grp_valid) && !(inhibit_col4 && grp_idx[1] == 2'd3);
        code_nxt    = present_nxt ? tpc_pkg::key_code(grp_idx[0], grp_idx[1]) : 4'd0;
    end

    // Register the reported pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_present <= 1'b0;
            tone_code    <= 4'd0;
        end else begin
            tone_present <= present_nxt;
            tone_code    <= code_nxt;
        end
    end

endmodule

// File: rtl/tpc_checker.sv
// Module tpc_checker
// Temporal properties of tone_pair_classifier, attached with bind.
// Observes the outputs and the per-band strobes and valid flags.
module tpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit_col4,
    input logic       tone_present,
    input logic [3:0] tone_code,
    input logic [1:0] grp_valid,
    input logic [1:0] meas_stb,
    input logic [1:0] tmo_stb
);

    AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_present |-> tone_code == 4'd0); // R10

    AST_INHIBIT_COL4: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_present && $past(inhibit_col4)) |-> !(tone_code inside {4'd13, 4'd14, 4'd15, 4'd0})); // R7

    AST_BOTH_BANDS: assert property (@(posedge clk) disable iff (!rst_n)
        tone_present |-> $past(grp_valid == 2'b11)); // R8

    AST_LOW_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_stb[0] |=> !grp_valid[0]); // R9

    AST_HIGH_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_stb[1] |=> !grp_valid[1]); // R9

    AST_LOW_RISE_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_valid[0]) |-> $past(meas_stb[0])); // R5

    AST_HIGH_RISE_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_valid[1]) |-> $past(meas_stb[1])); // R5

endmodule

bind tone_pair_classifier tpc_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit_col4 (inhibit_col4),
    .tone_present (tone_present),
    .tone_code    (tone_code),
    .grp_valid    (grp_valid),
    .meas_stb     (meas_stb),
    .tmo_stb      (tmo_stb)
);

// File: tb/tone_pair_classifier_tb_top.sv
`timescale 1ns/1ps
// Bench for tone_pair_classifier. It runs with the reference scaled down
// twentyfold so that whole digits fit in a short run. Expected values come
// from real-valued frequency arithmetic and a keypad character table.
module tone_pair_classifier_tb_top;

    localparam int REF = 178977;
    localparam int TMO = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_sq = 1'b0;
    logic       high_sq = 1'b0;
    logic       inh = 1'b0;
    logic       tone_present;
    logic [3:0] tone_code;

    int lo_per = 0;
    int hi_per = 0;
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    real   LOW_F [4] = '{697.0, 770.0, 852.0, 941.0};
    real   HIGH_F[4] = '{1209.0, 1336.0, 1477.0, 1633.0};
    string KEYS  [4] = '{"123A", "456B", "789C", "*0#D"};

    always #5 clk = ~clk;

    tone_pair_classifier #(
        .REF_HZ  (REF),
        .NAVG    (4),
        .TIMEOUT (TMO),
        .TOL_BP  (150),
        .CONFIRM (2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_sq       (low_sq),
        .high_sq      (high_sq),
        .inhibit_col4 (inh),
        .tone_present (tone_present),
        .tone_code    (tone_code)
    );

    // Square-wave generators, updated on falling edges.
    initial forever begin
        if (lo_per == 0) begin
            low_sq = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = lo_per;
            low_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            low_sq = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    initial forever begin
        if (hi_per == 0) begin
            high_sq = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = hi_per;
            high_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            high_sq = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    function automatic int exp_code(int r, int c);
        byte ch;
        ch = KEYS[r][c];
        case (ch)
            "0":     return 10;
            "*":     return 11;
            "#":     return 12;
            "A":     return 13;
            "B":     return 14;
            "C":     return 15;
            "D":     return 0;
            default: return int'(ch) - int'("0");
        endcase
    endfunction

    function automatic real nom(bit high, int i);
        return high ? HIGH_F[i] : LOW_F[i];
    endfunction

    function automatic real rel_dev(int per, real f);
        real fa;
        fa = real'(REF) / real'(per);
        return (fa > f) ? (fa - f) / f : (f - fa) / f;
    endfunction

    // Index of the nominal within ±1.5 %, or -1.
    function automatic int classify(int per, bit high);
        if (per == 0) return -1;
        for (int i = 0; i < 4; i++) begin
            if (rel_dev(per, nom(high, i)) <= 0.015) return i;
        end
        return -1;
    endfunction

    function automatic bit near_edge(int per, bit high);
        for (int i = 0; i < 4; i++) begin
            real d;
            d = rel_dev(per, nom(high, i));
            if (d > 0.013 && d < 0.017) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int per_for(real f, real dev);
        return $rtoi(real'(REF) / (f * (1.0 + dev)) + 0.5);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        lo_per = 0;
        hi_per = 0;
        repeat (TMO + 350) @(negedge clk);
    endtask

    // Silence, apply a pair, let it settle, compare against expectation.
    task automatic run_pair(int lp, int hp, bit ih, string req);
        int li;
        int hj;
        int ep;
        int ec;
        int m;
        quiet();
        inh    = ih;
        lo_per = lp;
        hi_per = hp;
        m = (lp > hp) ? lp : hp;
        repeat (11 * m + 64) @(negedge clk);
        li = classify(lp, 1'b0);
        hj = classify(hp, 1'b1);
        ep = (li >= 0 && hj >= 0 && !(ih && hj == 3)) ? 1 : 0;
        ec = (ep == 1) ? exp_code(li, hj) : 0;
        check(req, int'(tone_present), ep, "present");
        check({req, "/R10"}, int'(tone_code), ec, "code");
    endtask

    function automatic int pick(bit high, int idx, bit accept);
        int p;
        p = per_for(nom(high, idx), 0.0);
        for (int t = 0; t < 50; t++) begin
            real dev;
            if (accept) begin
                dev = (real'($urandom % 2401) - 1200.0) / 100000.0;
            end else begin
                dev = (2.0 + real'($urandom % 400) / 100.0) / 100.0;
                if ($urandom % 2 == 0) dev = -dev;
            end
            p = per_for(nom(high, idx), dev);
            if (!near_edge(p, high) && ((classify(p, high) >= 0) == accept)) return p;
        end
        return accept ? per_for(nom(high, idx), 0.0) : per_for(nom(high, idx), 0.05);
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state.
        repeat (4) @(negedge clk);
        check("R1", int'(tone_present), 0, "present in reset");
        check("R1", int'(tone_code), 0, "code in reset");
        rst_n = 1'b1;

        // R6 with R2 and R3: every key at nominal frequencies.
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                run_pair(per_for(LOW_F[r], 0.0), per_for(HIGH_F[c], 0.0), 1'b0, "R6/R2/R3");
            end
        end

        // R2, R3: near the acceptance edge.
        run_pair(per_for(LOW_F[0], 0.011), per_for(HIGH_F[2], -0.009), 1'b0, "R2/R3");
        run_pair(per_for(LOW_F[3], -0.011), per_for(HIGH_F[1], 0.009), 1'b0, "R2/R3");

        // R4: grey zone and clear rejection.
        run_pair(per_for(LOW_F[1], 0.025), per_for(HIGH_F[0], 0.0), 1'b0, "R4");
        run_pair(per_for(LOW_F[2], 0.0), per_for(HIGH_F[3], -0.05), 1'b0, "R4");

        // R7: inhibit masks column 3 only.
        run_pair(per_for(LOW_F[1], 0.0), per_for(HIGH_F[3], 0.0), 1'b1, "R7");
        run_pair(per_for(LOW_F[1], 0.0), per_for(HIGH_F[1], 0.0), 1'b1, "R7");

        // R8: a single band is never enough.
        run_pair(per_for(LOW_F[2], 0.0), 0, 1'b0, "R8");
        run_pair(0, per_for(HIGH_F[2], 0.0), 1'b0, "R8");

        // R5: not reported after six low periods.
        quiet();
        inh    = 1'b0;
        lo_per = per_for(LOW_F[0], 0.0);
        hi_per = per_for(HIGH_F[0], 0.0);
        repeat (6 * lo_per) @(negedge clk);
        check("R5", int'(tone_present), 0, "present after 6 periods");
        repeat (5 * lo_per + 64) @(negedge clk);
        check("R5", int'(tone_present), 1, "present after confirmation");

        // R9: drop the high tone, low tone keeps running.
        hi_per = 0;
        repeat (per_for(HIGH_F[0], 0.0) + TMO + 60) @(negedge clk);
        check("R9", int'(tone_present), 0, "present after timeout");
        check("R10", int'(tone_code), 0, "code after timeout");

        // R1: reset while a pair is reported.
        run_pair(per_for(LOW_F[2], 0.0), per_for(HIGH_F[0], 0.0), 1'b0, "R6");
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(tone_present), 0, "present under reset");
        check("R1", int'(tone_code), 0, "code under reset");
        rst_n = 1'b1;

        // Random pairs for R2, R3, R4, R6, R7.
        for (int k = 0; k < 10; k++) begin
            int  r;
            int  c;
            bit  al;
            bit  ah;
            bit  ih;
            r  = int'($urandom % 4);
            c  = int'($urandom % 4);
            al = ($urandom % 4) != 0;
            ah = ($urandom % 4) != 0;
            ih = ($urandom % 3) == 0;
            run_pair(pick(1'b0, r, al), pick(1'b1, c, ah), ih, "R2/R3/R4/R6/R7");
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule